// File: doc/BRIEF.md
# I2C Bit-Rate Divider

This block turns the system clock into the timing pulses that pace an I2C controller's bus phases. A 7-bit rate setting holds a 4-bit linear factor M and a 3-bit exponent N. The clock is divided in two cascaded stages:

- The first stage counts M+1 clocks.
- The second stage counts 2^(N+1) first-stage pulses. When the `ALT_POW` parameter is set, it counts 2^N instead.

The second-stage output is a one-cycle sample pulse. A modulo-10 phase counter advances on each sample pulse, so ten sample periods form one SCL bit period. The bus state machine uses the phase number to place SCL edges and SDA changes.

Software picks M and N and writes them in one cycle. A write restarts both divider stages and the phase counter, so the new rate begins from a clean boundary. Nothing of the old rate carries over.

Top module: `i2c_bitrate_gen`

## Requirements
- R1: After reset `rate_q` reads 0x44 (M=8, N=4) and `phase` reads 0.
- R2: When `rate_wr` is high at a clock edge, `rate_q` takes `rate_wdata` at that edge. M is bits 6:3 and N is bits 2:0.
- R3: In the default mode `sample_en` is a one-cycle pulse that repeats every (M+1)*2^(N+1) clocks.
- R4: With `ALT_POW` set, `sample_en` repeats every (M+1)*2^N clocks. With M=0 and N=0 it is high on every clock.
- R5: `phase` stays in the range 0..9. It advances by one on each `sample_en` and wraps from 9 to 0. Otherwise it holds.
- R6: `scl_tick` pulses on the sample pulse taken while `phase` is 9. The interval between `scl_tick` pulses is exactly 10*(M+1)*2^(N+1) clocks, and 10*(M+1)*2^N with `ALT_POW` set.
- R7: A write clears both divider stages and the phase counter. Counting the first cycle after the write as cycle 0, the first `sample_en` comes at cycle P-1, where P is the new sample period. The first `scl_tick` comes at cycle 10P-1.
- R8: Every M in 0..15 and every N in 0..7 gives the period of R3 and R4, including M=0,N=0 and M=15,N=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_wr | input | 1 | Write strobe for the rate setting |
| rate_wdata | input | 7 | New rate setting, {M[3:0], N[2:0]} |
| rate_q | output | 7 | Current rate setting |
| sample_en | output | 1 | One-cycle sample-rate pulse |
| phase | output | 4 | Sub-phase number 0..9 within the SCL period |
| scl_tick | output | 1 | One-cycle pulse at the end of each SCL period |

## Verification
The outputs depend only on how many clocks have passed since the last reset or write, and on the current M and N. A reference model built on that count predicts every output on every cycle.

A first-stage counter that is off by one moves the sample pulse within one sample period. A wrong power-of-two terminal count shows up at the first sample pulse. A phase counter that skips a value or wraps wrongly shows up within one SCL period, as a wrong `phase` or a misplaced `scl_tick`.

Period checks on `scl_tick` cover the following:
- the short extreme (M=0, N=0);
- the long extreme (M=15, N=7);
- writes made in the middle of a period;
- two writes on consecutive clocks.

// File: rtl/i2c_bitrate_gen.sv
module i2c_bitrate_gen #(
  parameter bit ALT_POW = 1'b0,
  parameter int MW = 4,
  parameter int NW = 3,
  parameter int SUB = 10,
  parameter logic [MW+NW-1:0] RST_RATE = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [MW+NW-1:0]  rate_wdata,
  output logic [MW+NW-1:0]  rate_q,
  output logic              sample_en,
  output logic [$clog2(SUB)-1:0] phase,
  output logic              scl_tick
);
  localparam int BW  = MW + NW;
  localparam int C2W = 1 << NW;
  localparam int PW  = $clog2(SUB);
  localparam logic [PW-1:0] PH_LAST = PW'(SUB - 1);

  logic [MW-1:0]  m_f;
  logic [NW-1:0]  n_f;
  logic [MW-1:0]  c1;
  logic [C2W-1:0] c2;
  logic [C2W:0]   k_span;
  logic [C2W-1:0] k_last;
  logic           en1;

  assign m_f    = rate_q[BW-1:NW];
  assign n_f    = rate_q[NW-1:0];
  assign k_span = (C2W+1)'(1) << (32'(n_f) + (ALT_POW ? 0 : 1));
  assign k_last = C2W'(k_span - 1'b1);

  assign en1       = (c1 == m_f);
  assign sample_en = en1 && (c2 == k_last);
  assign scl_tick  = sample_en && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RST_RATE;
      c1     <= '0;
      c2     <= '0;
      phase  <= '0;
    end else if (rate_wr) begin
      rate_q <= rate_wdata;
      c1     <= '0;
      c2     <= '0;
      phase  <= '0;
    end else begin
      c1 <= en1 ? '0 : c1 + 1'b1;
      if (en1) c2 <= (c2 == k_last) ? '0 : c2 + 1'b1;
      if (sample_en) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PH_LAST);

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !rate_wr && phase != PH_LAST) |=> phase == $past(phase) + 1'b1);

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !rate_wr) |=> $stable(phase));

  assert_wrap_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick |=> phase == '0);

  assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> (phase == '0 && rate_q == $past(rate_wdata)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !rate_wr && (m_f != '0 || k_last != '0)) |=> !sample_en);
endmodule

// File: tb/tb_i2c_bitrate_gen.sv
module tb_i2c_bitrate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_wr = 1'b0;
  logic [6:0] rate_wdata = '0;
  logic [6:0] q_d, q_a;
  logic se_d, se_a, st_d, st_a;
  logic [3:0] ph_d, ph_a;

  int checks = 0, errors = 0, cyc = 0;
  int t = 0, m_cur = 8, n_cur = 4;
  int last_d = -1, last_a = -1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bitrate_gen #(.ALT_POW(1'b0)) dut (.clk(clk), .rst_n(rst_n), .rate_wr(rate_wr),
    .rate_wdata(rate_wdata), .rate_q(q_d), .sample_en(se_d), .phase(ph_d), .scl_tick(st_d));
  i2c_bitrate_gen #(.ALT_POW(1'b1)) dut_alt (.clk(clk), .rst_n(rst_n), .rate_wr(rate_wr),
    .rate_wdata(rate_wdata), .rate_q(q_a), .sample_en(se_a), .phase(ph_a), .scl_tick(st_a));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model: cycles since reset or write, and current fields
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      t <= 0; m_cur <= 8; n_cur <= 4; last_d <= -1; last_a <= -1;
    end else if (rate_wr) begin
      t <= 0; m_cur <= int'(rate_wdata[6:3]); n_cur <= int'(rate_wdata[2:0]);
      last_d <= -1; last_a <= -1;
    end else begin
      t <= t + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(q_d == 7'h44, "R1 rate_q", int'(q_d), 'h44);
      chk(ph_d == 4'd0, "R1 phase", int'(ph_d), 0);
    end else if (!done) begin
      int pd, pa;
      pd = (m_cur + 1) << (n_cur + 1);
      pa = (m_cur + 1) << n_cur;
      chk(int'(q_d) == ((m_cur << 3) | n_cur), "R2 rate_q", int'(q_d), (m_cur << 3) | n_cur);
      chk(se_d == ((t % pd) == pd - 1), "R3 sample_en", int'(se_d), int'((t % pd) == pd - 1));
      chk(se_a == ((t % pa) == pa - 1), "R4 sample_en alt", int'(se_a), int'((t % pa) == pa - 1));
      chk(int'(ph_d) == (t / pd) % 10, "R5 phase", int'(ph_d), (t / pd) % 10);
      chk(int'(ph_a) == (t / pa) % 10, "R5 phase alt", int'(ph_a), (t / pa) % 10);
      chk(st_d == ((t % (10*pd)) == 10*pd - 1), "R6 scl_tick", int'(st_d), int'((t % (10*pd)) == 10*pd - 1));
      chk(st_a == ((t % (10*pa)) == 10*pa - 1), "R6 scl_tick alt", int'(st_a), int'((t % (10*pa)) == 10*pa - 1));
      if (st_d) begin
        if (last_d < 0) chk(t == 10*pd - 1, "R7 first scl period", t, 10*pd - 1);
        else chk(cyc - last_d == 10*pd, "R6 R8 scl period", cyc - last_d, 10*pd);
        last_d = cyc;
      end
      if (st_a) begin
        if (last_a < 0) chk(t == 10*pa - 1, "R7 first scl period alt", t, 10*pa - 1);
        else chk(cyc - last_a == 10*pa, "R4 R8 scl period alt", cyc - last_a, 10*pa);
        last_a = cyc;
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic write_rate(input int m, input int n);
    @(negedge clk);
    rate_wr = 1'b1;
    rate_wdata = 7'((m << 3) | n);
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2*2880 + 20);       // R1 default rate, two SCL periods
    write_rate(0, 0);        // R8 shortest
    idle(100);
    write_rate(3, 2);        // R2 R3
    idle(700);
    write_rate(3, 2);        // R7 restart mid period
    idle(150);
    @(negedge clk);          // R7 writes on consecutive clocks
    rate_wr = 1'b1; rate_wdata = 7'((6 << 3) | 1);
    @(negedge clk);
    rate_wdata = 7'((1 << 3) | 3);
    @(negedge clk);
    rate_wr = 1'b0;
    idle(400);
    write_rate(15, 7);       // R8 longest
    idle(2*40960 + 20);
    write_rate(5, 0);
    idle(300);
    done = 1'b1;
    finish_run();
  end
endmodule